// File: doc/BRIEF.md
# Four-Lane Bidirectional Serial-to-Parallel Output Driver

This block turns serial bit streams into a wide parallel word. Four shift lanes of twenty stages each run from one common clock, so four bits enter per clock and a full 80-bit word needs only twenty clocks. A direction input chooses whether each lane fills from its near end or from its far end. Each lane provides a cascade output, so several such blocks can be chained into a longer register.

A bank of 80 capture flops follows the lanes. While the capture control is high, the bank follows the lanes cycle by cycle. While it is low, the bank keeps its word and the lanes can load the next frame. A final registered stage either forces every output to one level or passes the captured word through, true or inverted. The host controls this stage with two inputs.

Top module: `quad_lane_sipo_driver`

## Requirements
- R1: A synchronous active-high `rst` clears every lane stage, every capture flop and `par_out` to zero. `cas_out` then reads zero in either direction.
- R2: With `shift_fwd` = 1, each rising edge moves every lane stage s to stage s+1 and loads stage 0 from `ser_near_in[L]`. `cas_out[L]` shows stage 19 of lane L.
- R3: With `shift_fwd` = 0, each rising edge moves every lane stage s to stage s-1 and loads stage 19 from `ser_far_in[L]`. `cas_out[L]` shows stage 0 of lane L.
- R4: Output bit `par_out[L*20+s]` belongs to stage s of lane L, where lane 0 is the lowest and bit 0 is lane 0 stage 0.
- R5: When `latch_open` = 1 at a rising edge, the capture bank takes the lane contents produced by that same edge. `par_out` shows the result right after that edge.
- R6: When `latch_open` = 0, the capture bank keeps its word while the lanes shift.
- R7: `show_data` = 0 with `true_pol` = 0 drives every `par_out` bit to 1 from the next edge.
- R8: `show_data` = 0 with `true_pol` = 1 drives every `par_out` bit to 0 from the next edge.
- R9: `show_data` = 1 with `true_pol` = 1 drives `par_out` with the captured word.
- R10: `show_data` = 1 with `true_pol` = 0 drives `par_out` with the bitwise inverse of the captured word.
- R11: `latch_open`, `show_data` and `true_pol` have no effect on lane shifting or on `cas_out`.
- R12: When `cas_out[0]` feeds `ser_near_in[1]` in forward mode, `cas_out[0]` repeats the lane 0 input 20 clocks later, and `cas_out[1]` repeats it 40 clocks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| shift_fwd | input | 1 | 1: shift toward stage 19; 0: shift toward stage 0 |
| latch_open | input | 1 | 1: capture bank follows the lanes; 0: bank holds |
| show_data | input | 1 | 0: force all outputs; 1: pass the captured word |
| true_pol | input | 1 | Polarity / forced level select (see R7 to R10) |
| ser_near_in | input | 4 | Per-lane serial input at stage 0, used in forward mode |
| ser_far_in | input | 4 | Per-lane serial input at stage 19, used in reverse mode |
| par_out | output | 80 | Registered parallel outputs |
| cas_out | output | 4 | Per-lane cascade output at the exit end for the current direction |

## Verification
Lane stages and `par_out` change at the same rising edge that samples the inputs. No register sits between them, so the result is due one edge after a stimulus, and `cas_out` follows the current `shift_fwd` at once. The bench changes inputs only just after a falling edge, compares `par_out` and `cas_out` with its own model at the next falling edge, and so each check falls half a period after the edge it judges. The chaining check counts applied bits and expects the lane 0 exit bit to be the bit applied 20 edges before, and the lane 1 exit bit to be the bit applied 40 edges before.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

  typedef enum logic {
    SHIFT_REV = 1'b0,
    SHIFT_FWD = 1'b1
  } shift_dir_e;

  // Output-stage decision for one bit: forced level or true/inverted data.
  function automatic logic drive_bit(input logic show, input logic pol,
                                     input logic q);
    if (!show) return ~pol;
    return pol ? q : ~q;
  endfunction

endpackage

// File: rtl/sipo_lane.sv
module sipo_lane #(
  parameter int unsigned STAGES = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fwd,
  input  logic              din_near,
  input  logic              din_far,
  output logic [STAGES-1:0] stage_q,
  output logic [STAGES-1:0] stage_d,
  output logic              cas_o
);
  import sipo_pkg::*;

  shift_dir_e dir;
  assign dir = shift_dir_e'(fwd);

  always_comb begin
    if (dir == SHIFT_FWD) stage_d = {stage_q[STAGES-2:0], din_near};
    else                  stage_d = {din_far, stage_q[STAGES-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= stage_d;
  end

  assign cas_o = (dir == SHIFT_FWD) ? stage_q[STAGES-1] : stage_q[0];

  // R2
  fwd_entry_chk: assert property (@(posedge clk) disable iff (rst)
    fwd |=> stage_q[0] == $past(din_near));
  // R2
  fwd_move_chk: assert property (@(posedge clk) disable iff (rst)
    fwd |=> stage_q[STAGES-1:1] == $past(stage_q[STAGES-2:0]));
  // R3
  rev_entry_chk: assert property (@(posedge clk) disable iff (rst)
    !fwd |=> stage_q[STAGES-1] == $past(din_far));
  // R3
  rev_move_chk: assert property (@(posedge clk) disable iff (rst)
    !fwd |=> stage_q[STAGES-2:0] == $past(stage_q[STAGES-1:1]));

endmodule

// File: rtl/sipo_hold.sv
module sipo_hold #(
  parameter int unsigned WIDTH = 80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q_next,
  output logic [WIDTH-1:0] q
);

  assign q_next = open ? d : q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !open |=> q == $past(q));
  // R5
  hold_follow_chk: assert property (@(posedge clk) disable iff (rst)
    open |=> q == $past(d));

endmodule

// File: rtl/sipo_drive.sv
module sipo_drive #(
  parameter int unsigned WIDTH = 80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             show,
  input  logic             pol,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] out_q
);
  import sipo_pkg::*;

  logic [WIDTH-1:0] out_d;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      assign out_d[i] = drive_bit(show, pol, d[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= out_d;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> out_q == '0);
  // R7
  force_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!show && !pol) |=> &out_q);
  // R8
  force_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!show && pol) |=> out_q == '0);
  // R9
  pass_true_chk: assert property (@(posedge clk) disable iff (rst)
    (show && pol) |=> out_q == $past(d));
  // R10
  pass_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (show && !pol) |=> out_q == ~$past(d));

endmodule

// File: rtl/quad_lane_sipo_driver.sv
module quad_lane_sipo_driver #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned STAGES = 20,
  localparam int unsigned WIDTH = LANES * STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_fwd,
  input  logic             latch_open,
  input  logic             show_data,
  input  logic             true_pol,
  input  logic [LANES-1:0] ser_near_in,
  input  logic [LANES-1:0] ser_far_in,
  output logic [WIDTH-1:0] par_out,
  output logic [LANES-1:0] cas_out
);

  logic [WIDTH-1:0] lane_q;
  logic [WIDTH-1:0] lane_d;
  logic [WIDTH-1:0] cap_next;
  logic [WIDTH-1:0] cap_q;

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      sipo_lane #(.STAGES(STAGES)) u_lane (
        .clk      (clk),
        .rst      (rst),
        .fwd      (shift_fwd),
        .din_near (ser_near_in[l]),
        .din_far  (ser_far_in[l]),
        .stage_q  (lane_q[l*STAGES +: STAGES]),
        .stage_d  (lane_d[l*STAGES +: STAGES]),
        .cas_o    (cas_out[l])
      );
    end
  endgenerate

  // Capture bank takes the lane value of the same edge (transparent in cycle terms).
  sipo_hold #(.WIDTH(WIDTH)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .open   (latch_open),
    .d      (lane_d),
    .q_next (cap_next),
    .q      (cap_q)
  );

  sipo_drive #(.WIDTH(WIDTH)) u_drive (
    .clk   (clk),
    .rst   (rst),
    .show  (show_data),
    .pol   (true_pol),
    .d     (cap_next),
    .out_q (par_out)
  );

  // R4
  map_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_open && show_data && true_pol) |=> par_out == lane_q);
  // R1
  reset_lane_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lane_q == '0 && cap_q == '0));

endmodule

// File: tb/tb_quad_lane_sipo_driver.sv
module tb_quad_lane_sipo_driver;

  localparam int LANES = 4;
  localparam int STAGES = 20;
  localparam int W = LANES * STAGES;

  logic clk = 1'b0;
  logic rst, fwd, le, show, pol;
  logic [LANES-1:0] near, far;
  logic [W-1:0] par_out;
  logic [LANES-1:0] cas_out;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit done = 0;

  bit [W-1:0] m_sr, m_hold, m_out;
  bit hist[$];
  logic [STAGES-1:0] pat [LANES];

  always #2 clk = ~clk;

  quad_lane_sipo_driver #(.LANES(LANES), .STAGES(STAGES)) dut (
    .clk(clk), .rst(rst), .shift_fwd(fwd), .latch_open(le),
    .show_data(show), .true_pol(pol), .ser_near_in(near),
    .ser_far_in(far), .par_out(par_out), .cas_out(cas_out)
  );

  // Behavioural reference, updated at every rising edge.
  always @(posedge clk) begin
    bit [W-1:0] nsr;
    if (rst) begin
      m_sr = '0; m_hold = '0; m_out = '0;
    end else begin
      for (int ln = 0; ln < LANES; ln++)
        for (int s = 0; s < STAGES; s++) begin
          int i;
          i = ln * STAGES + s;
          if (fwd) nsr[i] = (s == 0) ? near[ln] : m_sr[i-1];
          else     nsr[i] = (s == STAGES-1) ? far[ln] : m_sr[i+1];
        end
      m_sr = nsr;
      if (le) m_hold = nsr;
      for (int i = 0; i < W; i++)
        m_out[i] = show ? (pol ? m_hold[i] : !m_hold[i]) : !pol;
    end
  end

  function automatic logic [LANES-1:0] model_cas();
    logic [LANES-1:0] c;
    for (int ln = 0; ln < LANES; ln++)
      c[ln] = fwd ? m_sr[ln*STAGES + STAGES-1] : m_sr[ln*STAGES];
    return c;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare();
    chk(cur_req, par_out, m_out);
    chk(cur_req, W'(cas_out), W'(model_cas()));
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  function automatic logic [W-1:0] packed_pat();
    logic [W-1:0] v;
    for (int ln = 0; ln < LANES; ln++) v[ln*STAGES +: STAGES] = pat[ln];
    return v;
  endfunction

  task automatic do_reset();
    rst = 1'b1; near = '0; far = '0;
    step(); step();
    rst = 1'b0;
  endtask

  // Forward load: stage s ends up with pat[L][s]; latch opens on last bit only.
  task automatic load_fwd(bit open_last, bit noisy);
    fwd = 1'b1;
    for (int k = 0; k < STAGES; k++) begin
      for (int ln = 0; ln < LANES; ln++) near[ln] = pat[ln][STAGES-1-k];
      far = ~near;
      if (noisy) begin le = k[0]; show = k[1]; pol = k[2]; end
      else le = 1'b0;
      if (k == STAGES-1) begin
        le = open_last;
        if (noisy) begin show = 1'b1; pol = 1'b1; end
      end
      step();
    end
  endtask

  initial begin
    logic [W-1:0] held;
    rst = 1'b1; fwd = 1'b1; le = 1'b0; show = 1'b1; pol = 1'b1;
    near = '0; far = '0;
    cur_req = "R1";
    step(); step(); step();
    rst = 1'b0;
    chk("R1", par_out, '0);
    chk("R1", W'(cas_out), '0);

    // R2, R4 forward load with true polarity
    cur_req = "R2";
    pat[0] = 20'hA5C3F; pat[1] = 20'h0F0F1; pat[2] = 20'h80001; pat[3] = 20'h3C96E;
    load_fwd(1'b1, 1'b0);
    chk("R2", par_out, packed_pat());
    chk("R2", W'(cas_out), W'({pat[3][19], pat[2][19], pat[1][19], pat[0][19]}));
    held = packed_pat();

    // R6 hold during a new load, then R5 capture on the last edge
    cur_req = "R6";
    for (int ln = 0; ln < LANES; ln++) pat[ln] = ~pat[ln] ^ 20'h12345;
    fwd = 1'b1;
    for (int k = 0; k < STAGES-1; k++) begin
      for (int ln = 0; ln < LANES; ln++) near[ln] = pat[ln][STAGES-1-k];
      le = 1'b0;
      step();
    end
    chk("R6", par_out, held);
    cur_req = "R5";
    for (int ln = 0; ln < LANES; ln++) near[ln] = pat[ln][0];
    le = 1'b1;
    step();
    chk("R5", par_out, packed_pat());

    // R3 reverse load: value applied at step k ends in stage k
    cur_req = "R3";
    pat[0] = 20'h6B2D1; pat[1] = 20'hFFF00; pat[2] = 20'h00C0F; pat[3] = 20'h9E5A7;
    fwd = 1'b0;
    for (int k = 0; k < STAGES; k++) begin
      for (int ln = 0; ln < LANES; ln++) far[ln] = pat[ln][k];
      near = ~far;
      le = (k == STAGES-1);
      step();
    end
    chk("R3", par_out, packed_pat());
    chk("R3", W'(cas_out), W'({pat[3][0], pat[2][0], pat[1][0], pat[0][0]}));
    held = packed_pat();

    // R7..R10 output stage modes, latch closed
    le = 1'b0; near = '0; far = '0;
    cur_req = "R7"; show = 1'b0; pol = 1'b0; step();
    chk("R7", par_out, '1);
    cur_req = "R8"; show = 1'b0; pol = 1'b1; step();
    chk("R8", par_out, '0);
    cur_req = "R9"; show = 1'b1; pol = 1'b1; step();
    chk("R9", par_out, held);
    cur_req = "R10"; show = 1'b1; pol = 1'b0; step();
    chk("R10", par_out, ~held);

    // R4 single bit placement: lane 2, stage 6 -> bit 46
    cur_req = "R4";
    do_reset();
    fwd = 1'b1; le = 1'b1; show = 1'b1; pol = 1'b1;
    near = 4'b0100; step();
    near = '0;
    for (int k = 0; k < 6; k++) step();
    chk("R4", par_out, W'(1) << 46);

    // R11 controls toggling during a load do not disturb shifting
    cur_req = "R11";
    pat[0] = 20'hC0FFE; pat[1] = 20'h1D2E3; pat[2] = 20'h7A7A7; pat[3] = 20'h0BEEF;
    load_fwd(1'b1, 1'b1);
    chk("R11", par_out, packed_pat());
    chk("R11", W'(cas_out), W'({pat[3][19], pat[2][19], pat[1][19], pat[0][19]}));

    // R12 chained lanes: lane 0 exit feeds lane 1 entry
    cur_req = "R12";
    do_reset();
    fwd = 1'b1; le = 1'b0; show = 1'b1; pol = 1'b1;
    hist.delete();
    for (int n = 0; n < 70; n++) begin
      bit b;
      b = ((n * 7) % 5 < 2) ^ n[3];
      near[0] = b;
      near[1] = cas_out[0];
      near[3:2] = '0;
      hist.push_back(b);
      step();
      if (hist.size() >= 20) chk("R12", W'(cas_out[0]), W'(hist[hist.size()-20]));
      if (hist.size() >= 40) chk("R12", W'(cas_out[1]), W'(hist[hist.size()-40]));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule